// File: doc/BRIEF.md
# Write-Through Byte Cache with Least-Recently-Used Replacement

This block is a small fully associative data cache between a processor's byte load/store port and a slower backing memory. A store always writes its byte through to memory, whether it hits or misses. A miss of either kind first brings the whole enclosing block into the cache, so the cache allocates on writes as well as reads. Because memory always holds every stored byte, no line is ever dirty, and replacing a line never creates memory traffic.

The processor holds `cpu_valid` and its request fields steady until it sees `cpu_ready` high at a clock edge. At that edge the access completes. A load that hits completes in the cycle it is presented and makes no memory request. The memory side holds `mem_req` and its fields steady until `mem_ack` arrives for one cycle. For a read, the whole block is returned on `mem_rdata` in that same cycle. Two saturating-free counters report completed hits and misses.

Top module: `wt_cache`

## Requirements
- R1: The byte address splits into a tag in the upper ADDR_W-OFF_W bits and a byte offset in the low OFF_W bits. An access hits when any valid line holds its tag. A load returns the byte at that offset, and byte o of a line maps to bits [8*o+7:8*o].
- R2: On a load miss, one memory read is issued with `mem_write` low, the offset bits of `mem_addr` zero and the tag bits equal to the request's tag. The returned block fills a line, and the load then completes with byte `cpu_addr` of that block.
- R3: Every store, hit or miss, issues exactly one memory write of `cpu_wdata` to `cpu_addr`. It completes in the cycle that write is acknowledged.
- R4: A store also updates the cached copy of its byte. A later load of that byte hits and returns the stored value without any memory request.
- R5: On a store miss, the block fill finishes before the memory write is issued. The written byte is then merged into the filled line.
- R6: When every line is valid, a miss replaces the least recently used line. Both completed hits and fills count as uses.
- R7: A miss fills an invalid line whenever one exists, before evicting any valid line.
- R8: Replacing a line never issues a memory write. `mem_write` is high only while a store is being presented.
- R9: `hit_count` or `miss_count` rises by exactly one per completed access, and neither changes otherwise. An access that needed a fill counts as a miss.
- R10: `cpu_ready` stays low while a fill or a store write is outstanding. While `mem_req` waits for `mem_ack`, its address, write flag and data hold steady.
- R11: Reset invalidates every line, clears both counters and drops `mem_req`. After a reset, an access to a previously cached block misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_rdata | output | DATA_W | Load byte, meaningful when a load completes |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |
| mem_req | output | 1 | Memory request pending |
| mem_write | output | 1 | 1 = byte write, 0 = block read |
| mem_addr | output | ADDR_W | Byte address (block-aligned for reads) |
| mem_wdata | output | DATA_W | Byte being written |
| mem_rdata | input | DATA_W<<OFF_W | Returned block, byte o in bits [8*o+7:8*o] |
| mem_ack | input | 1 | Memory request done this cycle |

## Verification
The hardest case to reach from the ports is a replacement where recency truly decides the victim. Both lines must be valid, and the line that was filled first must have been refreshed by a hit, so that a fill-order policy would choose differently. The stimulus reaches this with a short directed chain of fills and hits. A store-miss eviction of a just-written line then shows that no write-back occurs. A long stream of accesses follows, drawn from a small address range so that hits and evictions interleave, with memory latency varying from one to three cycles.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int LINES  = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_valid,
  input  logic                       cpu_write,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic                       cpu_ready,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic [CNT_W-1:0]           hit_count,
  output logic [CNT_W-1:0]           miss_count,
  output logic                       mem_req,
  output logic                       mem_write,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [(DATA_W<<OFF_W)-1:0] mem_rdata,
  input  logic                       mem_ack
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int BLK_W = DATA_W << OFF_W;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} state_t;

  state_t            state;
  logic              missed;
  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [BLK_W-1:0]  line_data [LINES];
  logic [IDX_W-1:0]  line_age  [LINES];

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim;
  logic              done;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!hit_any && line_vld[i] && line_tag[i] == req_tag) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && !line_vld[i]) begin
        found  = 1'b1;
        victim = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 0; i < LINES; i++) begin
        if (line_age[i] == IDX_W'(LINES - 1)) victim = IDX_W'(i);
      end
    end
  end

  assign cpu_ready = (state == S_IDLE && cpu_valid && hit_any && !cpu_write) ||
                     (state == S_WRITE && mem_ack);
  assign cpu_rdata = line_data[hit_idx][DATA_W*req_off +: DATA_W];
  assign done      = cpu_valid && cpu_ready;

  assign mem_req   = (state != S_IDLE);
  assign mem_write = (state == S_WRITE);
  assign mem_addr  = (state == S_WRITE) ? cpu_addr : {req_tag, {OFF_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

  assign touch_en  = done || (state == S_FILL && mem_ack);
  assign touch_idx = (state == S_FILL) ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      missed     <= 1'b0;
      line_vld   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int i = 0; i < LINES; i++) begin
        line_tag[i]  <= '0;
        line_data[i] <= '0;
        line_age[i]  <= IDX_W'(i);
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (cpu_valid && !hit_any) begin
            state  <= S_FILL;
            missed <= 1'b1;
          end else if (cpu_valid && cpu_write) begin
            state <= S_WRITE;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            line_vld[victim]  <= 1'b1;
            line_tag[victim]  <= req_tag;
            line_data[victim] <= mem_rdata;
            state             <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (mem_ack) begin
            line_data[hit_idx][DATA_W*req_off +: DATA_W] <= cpu_wdata;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (done) begin
        missed <= 1'b0;
        if (missed) miss_count <= miss_count + CNT_W'(1);
        else        hit_count  <= hit_count + CNT_W'(1);
      end

      if (touch_en) begin
        for (int i = 0; i < LINES; i++) begin
          if (IDX_W'(i) == touch_idx)              line_age[i] <= '0;
          else if (line_age[i] < line_age[touch_idx]) line_age[i] <= line_age[i] + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_write,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_ready,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic              mem_req,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  logic [CNT_W:0] total;
  assign total = {1'b0, hit_count} + {1'b0, miss_count};

  a_r2_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_write |-> mem_addr[OFF_W-1:0] == '0 && !cpu_ready);

  a_r3_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && cpu_write |->
      mem_req && mem_write && mem_ack && mem_addr == cpu_addr && mem_wdata == cpu_wdata);

  a_r8_no_evict_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_write |-> cpu_valid && cpu_write);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready |=> total == $past(total) + 1'b1);

  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_valid && cpu_ready) |=> $stable(hit_count) && $stable(miss_count));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |-> !cpu_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_write));
endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
  .hit_count(hit_count), .miss_count(miss_count), .mem_req(mem_req),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 5, OW = 1, DW = 8, CW = 16, NL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic [CW-1:0] hit_count, miss_count;
  logic mem_req, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [2*DW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  wt_cache #(.ADDR_W(AW), .OFF_W(OW), .LINES(NL), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .hit_count(hit_count), .miss_count(miss_count),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem_m [32];
  bit         mv [NL];
  logic [3:0] mt [NL];
  logic [7:0] md [NL][2];
  int         lru_q[$];
  int         mhits = 0, mmiss = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) mv[i] = 1'b0;
    lru_q.delete();
    for (int i = 0; i < NL; i++) lru_q.push_back(i);
    mhits = 0; mmiss = 0;
  endtask

  task automatic touch(input int k);
    foreach (lru_q[j]) if (lru_q[j] == k) begin lru_q.delete(j); break; end
    lru_q.push_back(k);
  endtask

  function automatic int lookup(input logic [4:0] a);
    for (int i = 0; i < NL; i++) if (mv[i] && mt[i] == a[4:1]) return i;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cpu_valid = 1'b0; mem_ack = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R11", "hit_count", hit_count, 0);
    chk("R11", "miss_count", miss_count, 0);
    chk("R11", "mem_req", mem_req, 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic access(input bit w, input logic [4:0] a, input logic [7:0] d, input int lat, input string tag);
    int idx, v;
    bit miss;
    logic [4:0] base;
    idx  = lookup(a);
    miss = (idx < 0);
    base = {a[4:1], 1'b0};
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
    #1;
    chk(tag, "mem_req idle", mem_req, 0);
    if (!w && !miss) begin
      chk(tag, "ready hit", cpu_ready, 1);
      chk(tag, "rdata hit", cpu_rdata, md[idx][a[0]]);
    end else chk(tag, "ready idle", cpu_ready, 0);
    if (miss) begin
      v = -1;
      for (int i = 0; i < NL; i++) if (v < 0 && !mv[i]) v = i;
      if (v < 0) v = lru_q[0];
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        mem_rdata = {$urandom} [15:0];
        if (k == lat - 1) begin
          mem_ack = 1'b1;
          mem_rdata = {mem_m[base + 5'd1], mem_m[base]};
        end
        #1;
        chk(tag, "fill req", mem_req, 1);
        chk(mv[v] ? "R8" : tag, "fill is read", mem_write, 0);
        chk(tag, "fill addr", mem_addr, base);
        chk("R10", "ready in fill", cpu_ready, 0);
      end
      mv[v] = 1'b1; mt[v] = a[4:1];
      md[v][0] = mem_m[base]; md[v][1] = mem_m[base + 5'd1];
      touch(v);
      idx = v;
      @(negedge clk);
      mem_ack = 1'b0;
      #1;
      if (!w) begin
        chk(tag, "ready after fill", cpu_ready, 1);
        chk(tag, "rdata after fill", cpu_rdata, md[idx][a[0]]);
      end else begin
        chk("R5", "ready after fill", cpu_ready, 0);
        chk("R5", "no write before fill done", mem_req, 0);
      end
    end
    if (w) begin
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        if (k == lat - 1) mem_ack = 1'b1;
        #1;
        chk("R3", "write req", mem_req, 1);
        chk("R3", "write flag", mem_write, 1);
        chk("R3", "write addr", mem_addr, a);
        chk("R3", "write data", mem_wdata, d);
        chk("R10", "ready in write", cpu_ready, (k == lat - 1) ? 1 : 0);
      end
      mem_m[a] = d;
      md[idx][a[0]] = d;
    end
    touch(idx);
    if (miss) mmiss++; else mhits++;
    @(negedge clk);
    mem_ack = 1'b0; cpu_valid = 1'b0;
    #1;
    chk("R9", "hit_count", hit_count, mhits);
    chk("R9", "miss_count", miss_count, mmiss);
    chk(tag, "mem_req quiet", mem_req, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++) mem_m[i] = 8'((i * 37 + 11) & 255);
    model_reset();
    do_reset();
    // R7: two distinct blocks after reset both stay resident
    access(0, 5'd1, 0, 1, "R2");
    access(0, 5'd7, 0, 2, "R7");
    access(0, 5'd0, 0, 1, "R1");
    access(0, 5'd6, 0, 1, "R7");
    // R6: block 0 refreshed last, so block 3 is evicted by the next miss
    access(0, 5'd1, 0, 1, "R6");
    access(0, 5'd10, 0, 3, "R6");
    access(0, 5'd0, 0, 1, "R6");
    access(0, 5'd7, 0, 2, "R6");
    // R4: store hit then load hit returns the new byte
    access(1, 5'd7, 8'hA5, 2, "R4");
    access(0, 5'd7, 0, 1, "R4");
    // R5: store miss
    access(1, 5'd21, 8'h3C, 3, "R5");
    access(0, 5'd21, 0, 1, "R5");
    access(0, 5'd20, 0, 1, "R5");
    // R8: evict the written lines; fills must not write
    access(0, 5'd30, 0, 1, "R8");
    access(0, 5'd2, 0, 2, "R8");
    access(0, 5'd7, 0, 1, "R3");
    // R11: reset drops cached contents
    do_reset();
    access(0, 5'd2, 0, 1, "R11");
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      a = {2'b0, 3'($urandom)} + ((n % 3 == 0) ? 5'd8 : 5'd0);
      access($urandom_range(0, 1) == 1, a, 8'($urandom), $urandom_range(1, 3), "R1");
    end
    summary();
  end
endmodule